// File: doc/BRIEF.md
# Packed SIMD variable rounding shifter

This block shifts every lane of a 128-bit packed vector by its own signed amount. The amount for each lane comes from the low byte of the matching lane of a second vector. A positive amount shifts left. A negative amount shifts right by its magnitude. Rounding can add half of the last discarded weight before a right shift. The lane value can be read as signed or unsigned. Saturation can clamp each lane to its representable range, and a sticky flag records that a clamp happened.

The result is registered: operands and controls presented in one cycle appear at the outputs after the next rising clock edge. The active width can be the full 128 bits or the low 64 bits. A scalar mode processes a single lane at bit 0. Lanes outside the active width are driven to zero. Some combinations of controls are not allowed. For those, the block raises a configuration error output in place of a result.

Top module: `simd_rshift`

## Requirements
- R1: `lane_sz` selects the lane width W = 8 << lane_sz (0 → 8, 1 → 16, 2 → 32, 3 → 64). Lane e occupies bits [e*W +: W] of each operand and of the result. Its shift amount is bits [e*W +: 8] of `op_b`, read as two's complement, and the other bits of that `op_b` lane have no effect.
- R2: A positive amount k shifts the lane left by k. Without saturation the result is the low W bits of the shifted value, which is zero when k ≥ W. An amount of zero passes the lane through unchanged.
- R3: A negative amount −k shifts right by k, filling with zeros when `sgn`=0 and with copies of the sign bit when `sgn`=1. When k ≥ W the result is 0 for unsigned lanes and 0 or −1 for signed lanes, following the sign.
- R4: With `rnd`=1, a right shift by k adds 2^(k−1) to the extended lane value before shifting. Left shifts and zero shifts are not rounded.
- R5: With `sat_en`=1, a lane whose shifted value lies outside [0, 2^W−1] (unsigned) or [−2^(W−1), 2^(W−1)−1] (signed) is replaced by the nearest bound. With `sat_en`=0 no lane is ever clamped and the flag is never set.
- R6: `sat_flag` becomes 1 one edge after any active lane clamps. It then stays 1 until an edge where `sat_clr`=1. If a clamp happens in the same cycle as `sat_clr`=1, the flag is set.
- R7: Two combinations are illegal: vector mode with `lane_sz`=3 and `wide`=0, and scalar mode with `sat_en`=0 and `lane_sz`≠3. For either one, `cfg_bad` is 1 after the edge, `res` is zero and the flag is not set.
- R8: With `wide`=1 all 128 bits are active, and with `wide`=0 only bits [63:0] are active. In scalar mode only lane 0 is active and `wide` is ignored. Inactive result bits are zero, and inactive lanes never set the flag.
- R9: After reset `res`, `cfg_bad` and `sat_flag` are zero. Each result is captured at the first rising edge after its inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 128 | Lanes to be shifted |
| op_b | input | 128 | Per-lane shift amounts in the low byte of each lane |
| lane_sz | input | 2 | Lane width code |
| wide | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| scalar | input | 1 | 1: single lane at bit 0 |
| sgn | input | 1 | 1: lanes are signed |
| rnd | input | 1 | 1: round right shifts |
| sat_en | input | 1 | 1: clamp to lane range |
| sat_clr | input | 1 | Clears the sticky flag at the next edge |
| res | output | 128 | Registered result vector |
| cfg_bad | output | 1 | Registered illegal-configuration indication |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The sticky flag's clear and a new clamp can both happen at the same edge. The bench applies every table vector with `sat_clr` held high. As a result the flag after each vector shows only that vector's own clamping, and a clamping vector shows that the set wins over the clear. Directed steps then hold the clear low across a clamping vector followed by a clean vector, and check that the flag stays set. A final cycle applies the clear with no clamp and checks that the flag drops.

// File: rtl/simd_rshift.sv
module simd_rshift #(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] op_a,
  input  logic [VW-1:0] op_b,
  input  logic [1:0]    lane_sz,
  input  logic          wide,
  input  logic          scalar,
  input  logic          sgn,
  input  logic          rnd,
  input  logic          sat_en,
  input  logic          sat_clr,
  output logic [VW-1:0] res,
  output logic          cfg_bad,
  output logic          sat_flag
);
  localparam int HW = VW / 2;

  logic [7:0] act_w;
  logic       bad;
  logic [VW-1:0] rsel;
  logic       ssel;

  assign act_w = scalar ? (8'd8 << lane_sz) : (wide ? 8'(VW) : 8'(HW));
  assign bad   = scalar ? (!sat_en && lane_sz != 2'd3) : (lane_sz == 2'd3 && !wide);

  for (genvar s = 0; s < 4; s++) begin : g_sz
    localparam int W = 8 << s;
    localparam int N = VW / W;
    localparam logic [7:0] KMAX = 8'(W + 1);
    logic [VW-1:0] lres;
    logic [N-1:0]  lsat;

    for (genvar e = 0; e < N; e++) begin : g_ln
      logic signed [W+1:0]   x, pre, rp1, rgt;
      logic signed [2*W+1:0] lft, val;
      logic signed [7:0]     sh;
      logic [7:0]            mag, kc;
      logic                  act, ovf;
      logic [W-1:0]          clamp;

      assign sh  = op_b[e*W +: 8];
      assign x   = sgn ? {{2{op_a[e*W+W-1]}}, op_a[e*W +: W]} : {2'b00, op_a[e*W +: W]};
      assign mag = sh[7] ? 8'(-sh) : 8'(sh);
      assign kc  = (mag > KMAX) ? KMAX : mag;
      assign lft = {{W{x[W+1]}}, x} << kc;
      assign pre = x >>> (mag - 8'd1);
      assign rp1 = pre + (W+2)'(1);
      assign rgt = rnd ? (rp1 >>> 1) : (pre >>> 1);
      assign val = sh[7] ? {{W{rgt[W+1]}}, rgt} : lft;
      assign ovf = sgn ? !((&val[2*W+1:W-1]) || !(|val[2*W+1:W-1])) : (|val[2*W+1:W]);
      assign clamp = sgn ? (val[2*W+1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}})
                         : {W{1'b1}};
      assign act = act_w > 8'(e * W);
      assign lsat[e] = act && sat_en && ovf;
      assign lres[e*W +: W] = !act ? '0 : ((sat_en && ovf) ? clamp : val[W-1:0]);
    end
  end

  always_comb begin
    case (lane_sz)
      2'd0:    begin rsel = g_sz[0].lres; ssel = |g_sz[0].lsat; end
      2'd1:    begin rsel = g_sz[1].lres; ssel = |g_sz[1].lsat; end
      2'd2:    begin rsel = g_sz[2].lres; ssel = |g_sz[2].lsat; end
      default: begin rsel = g_sz[3].lres; ssel = |g_sz[3].lsat; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res      <= '0;
      cfg_bad  <= 1'b0;
      sat_flag <= 1'b0;
    end else begin
      res      <= bad ? '0 : rsel;
      cfg_bad  <= bad;
      sat_flag <= (sat_clr ? 1'b0 : sat_flag) | (!bad && ssel);
    end
  end

  AST_BAD_ZERO_RES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |-> res == '0); // R7
  AST_BAD_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!scalar && lane_sz == 2'd3 && !wide && sat_clr) |=> !sat_flag); // R7
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag); // R6
  AST_NOSAT_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_en && sat_clr) |=> !sat_flag); // R5
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!scalar && !wide) |=> res[VW-1:HW] == '0); // R8
  AST_SCALAR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    scalar |=> res[VW-1:HW] == '0); // R8
endmodule

// File: tb/simd_rshift_tb.sv
module simd_rshift_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [127:0] op_a = '0, op_b = '0;
  logic [1:0] lane_sz = '0;
  logic wide = 1'b0, scalar = 1'b0, sgn = 1'b0, rnd = 1'b0, sat_en = 1'b0, sat_clr = 1'b0;
  logic [127:0] res;
  logic cfg_bad, sat_flag;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  simd_rshift u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .lane_sz(lane_sz),
    .wide(wide), .scalar(scalar), .sgn(sgn), .rnd(rnd), .sat_en(sat_en),
    .sat_clr(sat_clr), .res(res), .cfg_bad(cfg_bad), .sat_flag(sat_flag)
  );

  typedef struct packed {
    logic [1:0]   sz;
    logic         wd, sc, sg, rn, st;
    logic [127:0] a, b, r;
    logic         fl, bd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 128'h01010101_01010101_01010101_01010101,
      128'h07060504_03020100_07060504_03020100, 128'h80402010_08040201_80402010_08040201, 1'b0, 1'b0}, // R1 R2
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
      128'h01010101_01010101_08070100_097F0203, 128'h00000000_00000000_0080FEFF_0000FCF8, 1'b0, 1'b0}, // R2 R8
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 128'h80008000_80008000_80008000_80008000,
      128'h00EF00FE_000000FC_008000F0_00F1ABFF, 128'h00002000_80000800_00000000_00014000, 1'b0, 1'b0}, // R3 R1
    '{2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 128'h80008000_80008000_80008000_80008000,
      128'h00EF00FE_000000FC_008000F0_00F1ABFF, 128'hFFFFE000_8000F800_FFFFFFFF_FFFFC000, 1'b0, 1'b0}, // R3
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 128'h80000000_FFFFFFFF_00000006_00000005,
      128'h000000DF_000000E0_000000FE_000000FF, 128'h00000000_00000001_00000002_00000003, 1'b0, 1'b0}, // R4
    '{2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 128'h80000000_00000003_FFFFFFFA_FFFFFFFB,
      128'h000000E0_00000002_000000FE_000000FF, 128'h00000000_0000000C_FFFFFFFF_FFFFFFFE, 1'b0, 1'b0}, // R4
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 128'h00000000_00000002_00000000_00000001,
      128'h00000000_0000003F_00000000_0000003F, 128'hFFFFFFFF_FFFFFFFF_80000000_00000000, 1'b1, 1'b0}, // R5 R6
    '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 128'h00000000_00000000_FF7F8100_01BFC040,
      128'h00000000_00000000_0700FF7F_7F010101, 128'h00000000_00000000_807FC000_7F80807F, 1'b1, 1'b0}, // R5
    '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 128'h7F7F7F7F_7F7F7F7F_00000000_00000000,
      128'h01010101_01010101_00000000_00000000, 128'h0, 1'b0, 1'b0}, // R8
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 128'hFFFFFFFF_FFFFFFFF_00000000_000000FF,
      128'h00000000_00000001_FFFFFFFF_FFFFFFFC, 128'h00000000_00000000_00000000_00000010, 1'b0, 1'b0}, // R8 R4
    '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFF4000,
      128'h01010101_01010101_01010101_01010001, 128'h00000000_00000000_00000000_00007FFF, 1'b1, 1'b0}, // R8 R5
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 128'h00000000_00000000_00000000_00000002,
      128'h00000000_00000000_00000000_0000003F, 128'h0, 1'b0, 1'b1}, // R7
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 128'h00000000_00000000_00000000_00000005,
      128'h00000000_00000000_00000000_00000001, 128'h0, 1'b0, 1'b1}, // R7
    '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_00000010,
      128'h00000000_00000000_00000000_000000FE, 128'h00000000_00000000_00000000_00000004, 1'b0, 1'b0}  // R8
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input logic clr);
    @(negedge clk);
    op_a = v.a; op_b = v.b; lane_sz = v.sz; wide = v.wd; scalar = v.sc;
    sgn = v.sg; rnd = v.rn; sat_en = v.st; sat_clr = clr;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset res", res, '0);
    chk("R9 reset flags", {126'd0, cfg_bad, sat_flag}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i], 1'b1);
      chk($sformatf("R1-table[%0d] res", i), res, TBL[i].r);
      chk($sformatf("R6 table[%0d] flag", i), {127'd0, sat_flag}, {127'd0, TBL[i].fl});
      chk($sformatf("R7 table[%0d] cfg_bad", i), {127'd0, cfg_bad}, {127'd0, TBL[i].bd});
    end

    // R6: the flag survives a clean vector while the clear is low
    apply(TBL[6], 1'b0);
    chk("R6 set", {127'd0, sat_flag}, 128'd1);
    apply(TBL[0], 1'b0);
    chk("R6 hold", {127'd0, sat_flag}, 128'd1);
    chk("R9 next result", res, TBL[0].r);
    apply(TBL[0], 1'b1);
    chk("R6 clear", {127'd0, sat_flag}, 128'd0);
    // R7: an illegal saturating vector with the clear low leaves the flag at zero
    apply(TBL[11], 1'b0);
    chk("R7 no flag", {127'd0, sat_flag}, 128'd0);
    // R5: the same saturating data without sat_en wraps instead
    begin
      vec_t v = TBL[6];
      v.st = 1'b0;
      apply(v, 1'b0);
      chk("R5 wrap", res, 128'h00000000_00000000_80000000_00000000);
      chk("R5 no flag", {127'd0, sat_flag}, 128'd0);
    end
    // R9: reset in mid-run clears every output
    apply(TBL[6], 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R9 async reset", {res[125:0], cfg_bad, sat_flag}, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule